// File: doc/BRIEF.md
# I2C Ten-Bit Address Slave Transmitter

This block is an I2C slave that answers read transfers addressed with a ten-bit address. It oversamples SCL and SDA on the system clock and drives two open-drain enables. When an enable is high, the matching line is pulled low. The SCL enable is used to stretch the clock. Addressing takes two steps. First, a write-phase header byte and a low address byte are matched. Then, after a repeated start, a header byte with the read bit set switches the block into transmitting.

The host side has four parts. The first is a single 8-bit match register that the host rewrites between address bytes; an update flag and a stretched SCL tell the host when to do so. The second is a receive stream that presents each acknowledged address byte. The third is a transmit stream that feeds data bytes. The last is a clock-release bit and a sticky interrupt flag. Both streams use valid/ready. The transmit side accepts a byte (`tx_valid` and `tx_ready` high in the same cycle) only while the shared buffer-full flag is low. The receive side holds `rx_valid` and `rx_data` until the host pulses `rx_ready`. Back-pressure is therefore the host's own choice: while the receive byte is not taken, no transmit byte is accepted.

Top module: `i2c10_slave_tx`

## Requirements
- R1: A start or repeated start is an SDA fall while SCL is high; a stop is an SDA rise while SCL is high. After reset and after any stop, the block drives neither SDA nor SCL low.
- R2: The first byte after a start is compared with the match register, bits 7..1 only. In the write phase this byte is {11110, A9, A8, 0}. SDA is pulled low on the ninth clock only when those bits are equal and bit 0 is 0, or when bit 0 is 1 and a two-byte match is in force. Otherwise the byte is not acknowledged.
- R3: In the write phase, the byte that follows an acknowledged header is acknowledged only when all 8 bits equal the match register, which then holds A7..A0.
- R4: The update flag is set on the ninth clock of each acknowledged write-phase address byte. It is cleared by a host write to the match register.
- R5: After the ninth clock of each acknowledged write-phase address byte, SCL is held low until the host writes the match register. SCL is never held low except while the update flag is set or while the clock-release bit is 0.
- R6: A read header ({11110, A9, A8, 1}) arriving after a two-byte match is acknowledged. After its ninth clock, the clock-release bit reads 0 and SCL stays low until the host sets the bit with `rel_set`.
- R7: `tx_ready` equals the inverse of `buf_full`. An accepted transmit byte sets `buf_full`, and the flag clears when the eighth data bit of that byte ends.
- R8: Data bits leave MSB first, one per SCL clock. SDA never changes while SCL is high.
- R9: The interrupt flag is set on the ninth clock of every acknowledged address byte and of every data byte. `irq_clr` clears it.
- R10: If the master acknowledges a data byte, the clock-release bit returns to 0 and SCL is held before the next byte. If the master does not acknowledge, SDA and SCL are released and the block stays idle until the next start.
- R11: A stop cancels any two-byte match. A read header after a stop without a new two-byte match is not acknowledged.
- R12: Each acknowledged address byte, including the read header, is placed on `rx_data` with `rx_valid` high. A `rx_ready` pulse clears `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| addr_wr | input | 1 | Write strobe for the match register |
| addr_wdata | input | 8 | Match register write data |
| upd_addr | output | 1 | Match register must be rewritten |
| tx_valid | input | 1 | Transmit byte offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte can be accepted |
| rx_valid | output | 1 | Received address byte available |
| rx_data | output | 8 | Received address byte |
| rx_ready | input | 1 | Host takes the received byte |
| buf_full | output | 1 | Receive or transmit buffer occupied |
| rel_set | input | 1 | Set the clock-release bit |
| clk_release | output | 1 | Clock-release bit (0 holds SCL while transmitting) |
| irq | output | 1 | Sticky event flag |
| irq_clr | input | 1 | Clear the event flag |

## Verification
The bench targets these corner cases:
- A header whose A8 bit is flipped, and a low byte differing in bit 0. A design comparing too few bits would acknowledge them.
- A read header sent after a stop instead of a repeated start. A design that keeps its match across the stop would start transmitting.
- The master's NACK on the final data byte. A design that keeps stretching, or keeps SDA low, there would hang the bus.
- The stretch points. The bench releases its own SCL while the slave should be holding the line, and it checks that data bytes come back bit-exact. A design that sampled bits on the wrong edge, or loaded the buffer late, would return shifted bytes.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HI   = 2'd1,
    PH_LO   = 2'd2,
    PH_TX   = 2'd3
  } phase_t;
endpackage

// File: rtl/i2c10_line_sync.sv
module i2c10_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q    = scl_pipe[STAGES-1];
  assign sda_q    = sda_pipe[STAGES-1];
  assign scl_rise = scl_q & ~scl_d;
  assign scl_fall = ~scl_q & scl_d;
  // SDA edges while SCL stays high are bus conditions
  assign start_ev = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_ev  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/i2c10_bit_fsm.sv
module i2c10_bit_fsm
  import i2c10_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_q,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic [BW-1:0] addr_q,
  input  logic [BW-1:0] txbuf,
  input  logic          ua,
  input  logic          ckp,
  output logic          ev_rx_load,
  output logic [BW-1:0] ev_rx_byte,
  output logic          ev_ua_set,
  output logic          ev_irq,
  output logic          ev_ckp_clr,
  output logic          ev_tx_sent,
  output logic          sda_oe,
  output logic          scl_oe
);
  localparam int CW = $clog2(BW + 2);
  localparam int IW = $clog2(BW);
  localparam logic [CW-1:0] C_ACK = CW'(BW);
  localparam logic [CW-1:0] C_END = CW'(BW + 1);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [BW-1:0] shreg;
  logic [IW-1:0] tx_idx;
  logic [BW-1:0] tx_sh;
  logic hit, matched, ack_drv, tx_on, mack, ua_hold;
  logic addr_ok, active, rise9, fall9, rw_bit;

  assign active = (phase != PH_IDLE) && !start_ev && !stop_ev;
  assign rw_bit = shreg[0];

  always_comb begin
    addr_ok = 1'b0;
    if (phase == PH_HI)
      addr_ok = (shreg[BW-1:1] == addr_q[BW-1:1]) && (!rw_bit || matched);
    else if (phase == PH_LO)
      addr_ok = (shreg == addr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      tx_idx  <= '0;
      hit     <= 1'b0;
      matched <= 1'b0;
      ack_drv <= 1'b0;
      tx_on   <= 1'b0;
      mack    <= 1'b0;
      ua_hold <= 1'b0;
    end else begin
      if (!ua) ua_hold <= 1'b0;
      if (stop_ev) begin
        phase   <= PH_IDLE;
        matched <= 1'b0;
        ack_drv <= 1'b0;
        tx_on   <= 1'b0;
        ua_hold <= 1'b0;
        cnt     <= '0;
      end else if (start_ev) begin
        phase   <= PH_HI;
        cnt     <= '0;
        hit     <= 1'b0;
        ack_drv <= 1'b0;
        tx_on   <= 1'b0;
        ua_hold <= 1'b0;
      end else if (phase != PH_IDLE) begin
        if (scl_rise) begin
          cnt <= cnt + 1'b1;
          if (cnt < C_ACK) shreg <= {shreg[BW-2:0], sda_q};
          if (cnt == C_ACK && phase == PH_TX) mack <= ~sda_q;
        end else if (scl_fall) begin
          if (cnt == C_ACK) begin
            if (phase == PH_TX) tx_on <= 1'b0;
            else begin
              hit     <= addr_ok;
              ack_drv <= addr_ok;
            end
          end else if (cnt == C_END) begin
            cnt     <= '0;
            ack_drv <= 1'b0;
            case (phase)
              PH_HI: begin
                if (!hit) phase <= PH_IDLE;
                else if (rw_bit) begin
                  phase  <= PH_TX;
                  tx_on  <= 1'b1;
                  tx_idx <= '0;
                end else begin
                  phase   <= PH_LO;
                  matched <= 1'b0;
                  ua_hold <= ua;
                end
              end
              PH_LO: begin
                if (hit) begin
                  matched <= 1'b1;
                  ua_hold <= ua;
                end
                phase <= PH_IDLE;
              end
              default: begin
                if (mack) begin
                  tx_on  <= 1'b1;
                  tx_idx <= '0;
                end else phase <= PH_IDLE;
              end
            endcase
          end else if (phase == PH_TX && cnt != '0) begin
            tx_idx <= cnt[IW-1:0];
          end
        end
      end
    end
  end

  assign rise9      = active && scl_rise && cnt == C_ACK;
  assign fall9      = active && scl_fall && cnt == C_END;
  assign ev_rx_load = rise9 && phase != PH_TX && hit;
  assign ev_rx_byte = shreg;
  assign ev_ua_set  = ev_rx_load && !(phase == PH_HI && rw_bit);
  assign ev_irq     = rise9 && (phase == PH_TX || hit);
  assign ev_ckp_clr = fall9 && ((phase == PH_HI && hit && rw_bit) || (phase == PH_TX && mack));
  assign ev_tx_sent = active && scl_fall && cnt == C_ACK && phase == PH_TX;

  assign tx_sh  = txbuf << tx_idx;
  assign sda_oe = ack_drv | (tx_on & ~tx_sh[BW-1]);
  assign scl_oe = (ua_hold & ua) | ~ckp;
endmodule

// File: rtl/i2c10_host_regs.sv
module i2c10_host_regs #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_wr,
  input  logic [BW-1:0] addr_wdata,
  input  logic          tx_valid,
  input  logic [BW-1:0] tx_data,
  input  logic          rx_ready,
  input  logic          rel_set,
  input  logic          irq_clr,
  input  logic          ev_rx_load,
  input  logic [BW-1:0] ev_rx_byte,
  input  logic          ev_ua_set,
  input  logic          ev_irq,
  input  logic          ev_ckp_clr,
  input  logic          ev_tx_sent,
  input  logic          ev_stop,
  output logic [BW-1:0] addr_q,
  output logic [BW-1:0] txbuf,
  output logic [BW-1:0] rxbuf,
  output logic          ua,
  output logic          ckp,
  output logic          irq,
  output logic          rx_full,
  output logic          tx_ready,
  output logic          buf_full
);
  logic tx_full;

  assign buf_full = rx_full | tx_full;
  assign tx_ready = ~buf_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      txbuf   <= '0;
      rxbuf   <= '0;
      ua      <= 1'b0;
      ckp     <= 1'b1;
      irq     <= 1'b0;
      rx_full <= 1'b0;
      tx_full <= 1'b0;
    end else begin
      if (addr_wr) addr_q <= addr_wdata;
      if (ev_ua_set) ua <= 1'b1;
      if (addr_wr) ua <= 1'b0;

      if (rel_set) ckp <= 1'b1;
      if (ev_ckp_clr) ckp <= 1'b0;
      if (ev_stop) ckp <= 1'b1;

      if (ev_irq) irq <= 1'b1;
      if (irq_clr) irq <= 1'b0;

      if (rx_ready && rx_full) rx_full <= 1'b0;
      if (ev_rx_load) begin
        rx_full <= 1'b1;
        rxbuf   <= ev_rx_byte;
      end

      if (ev_tx_sent) tx_full <= 1'b0;
      if (tx_valid && tx_ready) begin
        txbuf   <= tx_data;
        tx_full <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2c10_slave_tx.sv
module i2c10_slave_tx #(
  parameter int BW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          addr_wr,
  input  logic [BW-1:0] addr_wdata,
  output logic          upd_addr,
  input  logic          tx_valid,
  input  logic [BW-1:0] tx_data,
  output logic          tx_ready,
  output logic          rx_valid,
  output logic [BW-1:0] rx_data,
  input  logic          rx_ready,
  output logic          buf_full,
  input  logic          rel_set,
  output logic          clk_release,
  output logic          irq,
  input  logic          irq_clr
);
  logic scl_q, sda_q, scl_rise, scl_fall, start_ev, stop_ev;
  logic ev_rx_load, ev_ua_set, ev_irq, ev_ckp_clr, ev_tx_sent;
  logic [BW-1:0] ev_rx_byte, addr_q, txbuf;

  i2c10_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_q(scl_q), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c10_bit_fsm #(.BW(BW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .addr_q(addr_q), .txbuf(txbuf),
    .ua(upd_addr), .ckp(clk_release), .ev_rx_load(ev_rx_load), .ev_rx_byte(ev_rx_byte),
    .ev_ua_set(ev_ua_set), .ev_irq(ev_irq), .ev_ckp_clr(ev_ckp_clr), .ev_tx_sent(ev_tx_sent),
    .sda_oe(sda_oe), .scl_oe(scl_oe)
  );

  i2c10_host_regs #(.BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .rx_ready(rx_ready), .rel_set(rel_set),
    .irq_clr(irq_clr), .ev_rx_load(ev_rx_load), .ev_rx_byte(ev_rx_byte),
    .ev_ua_set(ev_ua_set), .ev_irq(ev_irq), .ev_ckp_clr(ev_ckp_clr),
    .ev_tx_sent(ev_tx_sent), .ev_stop(stop_ev), .addr_q(addr_q), .txbuf(txbuf),
    .rxbuf(rx_data), .ua(upd_addr), .ckp(clk_release), .irq(irq), .rx_full(rx_valid),
    .tx_ready(tx_ready), .buf_full(buf_full)
  );
endmodule

// File: rtl/i2c10_slave_tx_chk.sv
module i2c10_slave_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_q,
  input logic start_ev,
  input logic stop_ev,
  input logic sda_oe,
  input logic scl_oe,
  input logic addr_wr,
  input logic upd_addr,
  input logic clk_release,
  input logic tx_valid,
  input logic tx_ready,
  input logic buf_full,
  input logic irq,
  input logic irq_clr
);
  // R1: a stop leaves SDA released
  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe);

  // R4: register write clears the update flag
  p_ua_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> !upd_addr);

  // R5: stretching only for a pending update or a withheld release
  p_hold_reason_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> (upd_addr || !clk_release));

  // R7: an accepted transmit byte marks the buffer full
  p_bf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> buf_full);

  // R8: SDA drive is stable across a high SCL phase
  p_sda_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && $past(scl_q) && !$past(start_ev) && !$past(stop_ev)) |-> $stable(sda_oe));

  // R9: clear input drops the event flag
  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq);
endmodule

bind i2c10_slave_tx i2c10_slave_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_q(scl_q), .start_ev(start_ev), .stop_ev(stop_ev),
  .sda_oe(sda_oe), .scl_oe(scl_oe), .addr_wr(addr_wr), .upd_addr(upd_addr),
  .clk_release(clk_release), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .buf_full(buf_full), .irq(irq), .irq_clr(irq_clr)
);

// File: tb/tb_i2c10_slave_tx.sv
module tb_i2c10_slave_tx;
  localparam int H = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_bus, sda_bus;
  logic scl_oe, sda_oe, upd_addr, tx_ready, rx_valid, buf_full, clk_release, irq;
  logic [7:0] rx_data;
  logic addr_wr = 1'b0, tx_valid = 1'b0, rx_ready = 1'b0, rel_set = 1'b0, irq_clr = 1'b0;
  logic [7:0] addr_wdata = '0, tx_data = '0;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  assign scl_bus = !(m_scl_low || scl_oe);
  assign sda_bus = !(m_sda_low || sda_oe);

  i2c10_slave_tx dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
    .upd_addr(upd_addr), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready), .buf_full(buf_full),
    .rel_set(rel_set), .clk_release(clk_release), .irq(irq), .irq_clr(irq_clr)
  );

  function automatic logic [7:0] hdr(input logic [9:0] a, input logic rw);
    return {5'b11110, a[9:8], rw};
  endfunction

  function automatic logic [7:0] lo_byte(input logic [9:0] a);
    return a[7:0];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_bus) @(negedge clk);
  endtask

  task automatic pulse(output logic b);
    m_scl_low = 1'b0; tick(1); wait_scl_high();
    tick(H/2); b = sda_bus; tick(H/2);
    m_scl_low = 1'b1; tick(H);
  endtask

  task automatic bus_start();
    m_sda_low = 1'b0; tick(H);
    m_scl_low = 1'b0; tick(1); wait_scl_high(); tick(H);
    m_sda_low = 1'b1; tick(H);
    m_scl_low = 1'b1; tick(H);
  endtask

  task automatic bus_stop();
    m_scl_low = 1'b1; tick(H);
    m_sda_low = 1'b1; tick(H);
    m_scl_low = 1'b0; tick(1); wait_scl_high(); tick(H);
    m_sda_low = 1'b0; tick(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      m_sda_low = !b[i]; tick(2); pulse(x);
    end
    m_sda_low = 1'b0; tick(2); pulse(x);
    ack = !x;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic x;
    m_sda_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      pulse(x); d[i] = x;
    end
    m_sda_low = give_ack; tick(2); pulse(x);
    m_sda_low = 1'b0; tick(2);
  endtask

  task automatic host_addr(input logic [7:0] v);
    addr_wdata = v; addr_wr = 1'b1; tick(1); addr_wr = 1'b0; tick(1);
  endtask

  task automatic host_pop();
    rx_ready = 1'b1; tick(1); rx_ready = 1'b0; tick(1);
  endtask

  task automatic host_irq_clr();
    irq_clr = 1'b1; tick(1); irq_clr = 1'b0; tick(1);
  endtask

  task automatic host_tx(input logic [7:0] v);
    tx_data = v; tx_valid = 1'b1; tick(1); tx_valid = 1'b0; tick(1);
  endtask

  task automatic host_rel();
    rel_set = 1'b1; tick(1); rel_set = 1'b0; tick(1);
  endtask

  // two-byte write-phase match, leaves register loaded with the header
  task automatic match_two(input logic [9:0] a, input logic probe);
    logic ack;
    host_addr(hdr(a, 1'b0));
    bus_start();
    send_byte(hdr(a, 1'b0), ack);
    chk("R2 header ack", ack, 1);
    chk("R9 irq on header", irq, 1);
    chk("R4 update flag after header", upd_addr, 1);
    chk("R12 rx valid header", rx_valid, 1);
    chk("R12 rx data header", rx_data, hdr(a, 1'b0));
    chk("R5 scl held after header", scl_oe, 1);
    if (probe) begin
      m_scl_low = 1'b0; tick(H);
      chk("R5 bus SCL stays low", scl_bus, 0);
      m_scl_low = 1'b1; tick(2);
    end
    host_pop();
    chk("R12 rx popped", rx_valid, 0);
    host_irq_clr();
    chk("R9 irq cleared", irq, 0);
    host_addr(lo_byte(a));
    chk("R4 update flag cleared", upd_addr, 0);
    chk("R5 scl released", scl_oe, 0);
    send_byte(lo_byte(a), ack);
    chk("R3 low byte ack", ack, 1);
    chk("R4 update flag after low byte", upd_addr, 1);
    chk("R5 scl held after low byte", scl_oe, 1);
    chk("R12 rx data low", rx_data, lo_byte(a));
    host_pop();
    host_irq_clr();
    host_addr(hdr(a, 1'b0));
    chk("R5 scl released low", scl_oe, 0);
  endtask

  task automatic read_xfer(input logic [9:0] a, input int n, input logic probe);
    logic ack;
    logic [7:0] d, got;
    match_two(a, probe);
    bus_start();
    send_byte(hdr(a, 1'b1), ack);
    chk("R6 read header ack", ack, 1);
    chk("R6 release cleared", clk_release, 0);
    chk("R6 scl held", scl_oe, 1);
    chk("R4 no update flag on read header", upd_addr, 0);
    chk("R12 rx data read header", rx_data, hdr(a, 1'b1));
    chk("R7 ready blocked by rx", tx_ready, 0);
    host_pop();
    host_irq_clr();
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      if (k == 0 && probe) d = 8'hA5;
      chk("R7 ready before load", tx_ready, 1);
      host_tx(d);
      chk("R7 buf full after load", buf_full, 1);
      chk("R7 ready low", tx_ready, 0);
      host_rel();
      chk("R6 release set frees scl", scl_oe, 0);
      recv_byte(k != n - 1, got);
      chk("R8 data byte msb first", got, d);
      chk("R7 buf empty after byte", buf_full, 0);
      chk("R9 irq on data byte", irq, 1);
      host_irq_clr();
      if (k != n - 1) begin
        chk("R10 ack holds scl", scl_oe, 1);
        chk("R10 ack clears release", clk_release, 0);
      end else begin
        chk("R10 nack releases sda", sda_oe, 0);
        chk("R10 nack releases scl", scl_oe, 0);
      end
    end
    bus_stop();
    chk("R1 sda free after stop", sda_oe, 0);
  endtask

  task automatic neg_header(input logic [9:0] a);
    logic ack;
    host_addr(hdr(a, 1'b0));
    bus_start();
    send_byte(hdr(a ^ 10'h100, 1'b0), ack);
    chk("R2 wrong A8 not acked", ack, 0);
    chk("R9 no irq on mismatch", irq, 0);
    chk("R12 no rx on mismatch", rx_valid, 0);
    bus_stop();
  endtask

  task automatic neg_low(input logic [9:0] a);
    logic ack;
    host_addr(hdr(a, 1'b0));
    bus_start();
    send_byte(hdr(a, 1'b0), ack);
    host_pop(); host_irq_clr();
    host_addr(lo_byte(a));
    send_byte(lo_byte(a) ^ 8'h01, ack);
    chk("R3 wrong low byte not acked", ack, 0);
    chk("R4 no update flag on mismatch", upd_addr, 0);
    chk("R9 no irq on low mismatch", irq, 0);
    bus_stop();
  endtask

  task automatic neg_after_stop(input logic [9:0] a);
    logic ack;
    match_two(a, 1'b0);
    bus_stop();
    bus_start();
    send_byte(hdr(a, 1'b1), ack);
    chk("R11 read after stop not acked", ack, 0);
    chk("R11 no drive after stop", sda_oe, 0);
    chk("R11 no stretch after stop", scl_oe, 0);
    bus_stop();
  endtask

  initial begin : main
    logic ack;
    logic [9:0] a;
    void'($urandom(32'h1c2a5eed));
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R1 reset sda", sda_oe, 0);
    chk("R1 reset scl", scl_oe, 0);
    chk("R4 reset update flag", upd_addr, 0);
    chk("R7 reset buf", buf_full, 0);
    chk("R9 reset irq", irq, 0);
    chk("R6 reset release", clk_release, 1);

    // read header with no match since reset
    host_addr(hdr(10'h2C5, 1'b0));
    bus_start();
    send_byte(hdr(10'h2C5, 1'b1), ack);
    chk("R11 read without match not acked", ack, 0);
    bus_stop();

    read_xfer(10'h3FF, 2, 1'b1);
    neg_header(10'h155);
    neg_low(10'h0AA);
    neg_after_stop(10'h2C5);

    for (int it = 0; it < 6; it++) begin
      a = 10'($urandom);
      case ($urandom % 4)
        0: neg_header(a);
        1: neg_low(a);
        default: read_xfer(a, 1 + int'($urandom % 3), 1'b0);
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule